// File: doc/BRIEF.md
# Colour-Matrix Coefficient Encoder

This block converts one colour-conversion matrix coefficient from a wide sign-magnitude fixed-point word into the 16-bit code that a colour space converter's multiplier array consumes. The input carries its sign in the top bit. The remaining 63 bits hold the magnitude, with 32 fractional bits. Any range scaling is assumed to be already applied to the input.

Two encodings are offered. The float encoding splits the code into a sign, a 3-bit range code and a 12-bit field holding a rounded 9-bit mantissa. The range codes run 3, 2, 1, 0, 7, 6 from the smallest range to the largest, so they are not in numeric order. The fixed encoding packs the sign, three integer bits and twelve fraction bits. The result is registered and appears one cycle after a valid strobe, together with a delayed copy of that strobe.

Top module: `csc_coef_enc`

## Requirements
- R1: Output bit 15 equals input bit 63 in both encodings, for every accepted coefficient.
- R2: With mode_i = 0 (float), bits 14:12 hold the range code chosen from the magnitude m. The code is 3 for m < 0.125, 2 for m < 0.25, 1 for m < 0.5, 0 for m < 1.0, 7 for m < 2.0, and 6 for any larger m. Codes 4 and 5 never appear.
- R3: In float mode, bits 11:0 are formed in three steps. First m is scaled by 2^15, 2^14, 2^13, 2^12, 2^11 or 2^10 for codes 3, 2, 1, 0, 7 and 6 respectively, and the result is truncated. Then 4 is added, and the sum saturates at 0xFFF. Finally bits 2:0 are cleared.
- R4: In float mode, a magnitude of 4.0 or more is first replaced by 4.0 - 2^-32, so it encodes as 0x6FF8 with the sign in bit 15.
- R5: With mode_i = 1 (fixed), bits 14:12 hold integer bits 2:0 of m, and bits 11:0 hold the 12 most significant fraction bits, taken by truncation.
- R6: In fixed mode, a magnitude of 8.0 or more saturates to 0x7FFF with the sign in bit 15.
- R7: An exact zero magnitude encodes as 0x0000 when positive and 0x8000 when negative, in both encodings.
- R8: code_o updates on the clock edge that samples valid_i high. valid_o equals valid_i delayed by one cycle.
- R9: While valid_i is low, code_o holds its value whatever coef_i and mode_i do.
- R10: During reset, code_o reads 0x0000 and valid_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Coefficient strobe |
| mode_i | input | 1 | 0 selects the float encoding, 1 selects the fixed encoding |
| coef_i | input | 64 | Sign-magnitude coefficient with 32 fractional bits |
| valid_o | output | 1 | Strobe delayed by one cycle |
| code_o | output | 16 | Encoded coefficient |

## Verification
The bench places magnitudes exactly on each range boundary (0.125, 0.25, 0.5, 1.0 and 2.0). A comparator that uses <= instead of < at a boundary would produce the wrong range code and a mantissa that is twice or half its proper value. Mantissas are chosen just below and just above a rounding step, with lower bits set, to catch rounding at the wrong bit or rounding applied to bits that should be truncated. Values just under each range ceiling must saturate to 0xFF8 rather than wrap to zero. Inputs at or above 4.0, and at or above 8.0 in fixed mode, must clamp. The set also includes a lone set bit 62 and a value equal to the limit itself. The bench separates a true zero from a tiny non-zero value: the tiny value must keep range code 3 (0x3000), while a true zero, positive or negative, must give 0x0000 or 0x8000.

// File: rtl/csc_coef_pkg.sv
package csc_coef_pkg;
  localparam int unsigned COEF_W   = 64;
  localparam int unsigned FRAC_W   = 32;
  localparam int unsigned EXP_W    = 3;
  localparam int unsigned FIELD_W  = 12;
  localparam int unsigned RND_LSB  = 3;
  localparam int unsigned N_RANGE  = 6;

  typedef enum logic {
    ENC_FLOAT = 1'b0,
    ENC_FIXED = 1'b1
  } enc_mode_e;

  // range index 0..5 (smallest first) -> code 3,2,1,0,7,6
  function automatic logic [EXP_W-1:0] range_code(input logic [EXP_W-1:0] idx);
    return EXP_W'(3'd3 - idx);
  endfunction
endpackage

// File: rtl/coef_range_sel.sv
module coef_range_sel #(
  parameter int unsigned MAG_W   = 63,
  parameter int unsigned FRAC_W  = 32,
  parameter int unsigned N_RANGE = 6,
  parameter int unsigned CLAMP_W = FRAC_W + N_RANGE - 4,
  parameter int unsigned IDX_W   = $clog2(N_RANGE)
) (
  input  logic [MAG_W-1:0]   mag_i,
  output logic [CLAMP_W-1:0] mag_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam int unsigned LOW_EXP = FRAC_W - 3;  // first threshold 2^-3

  logic over;
  assign over  = |mag_i[MAG_W-1:CLAMP_W];
  assign mag_o = over ? '1 : mag_i[CLAMP_W-1:0];

  logic [N_RANGE-2:0] ge;
  for (genvar g = 0; g < N_RANGE - 1; g++) begin : g_thr
    assign ge[g] = |mag_o[CLAMP_W-1:LOW_EXP+g];
  end

  // thermometer -> index
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N_RANGE - 1; k++) idx_o = idx_o + IDX_W'(ge[k]);
  end
endmodule

// File: rtl/coef_mant_round.sv
module coef_mant_round #(
  parameter int unsigned MAG_W   = 34,
  parameter int unsigned FRAC_W  = 32,
  parameter int unsigned FIELD_W = 12,
  parameter int unsigned RND_LSB = 3,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [MAG_W-1:0]   mag_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [FIELD_W-1:0] field_o
);
  localparam int unsigned BASE_SH = FRAC_W - FIELD_W - 3;
  localparam logic [FIELD_W:0]   RND  = (FIELD_W+1)'(1) << (RND_LSB - 1);
  localparam logic [FIELD_W-1:0] MASK = ~((FIELD_W)'(1 << RND_LSB) - FIELD_W'(1));

  logic [MAG_W-1:0]   sh;
  logic [FIELD_W:0]   sum;
  logic               sat;
  logic [FIELD_W-1:0] pre;

  assign sh      = mag_i >> (BASE_SH + 32'(idx_i));
  assign sum     = {1'b0, sh[FIELD_W-1:0]} + RND;
  assign sat     = (|sh[MAG_W-1:FIELD_W]) | sum[FIELD_W];
  assign pre     = sat ? '1 : sum[FIELD_W-1:0];
  assign field_o = pre & MASK;
endmodule

// File: rtl/coef_fixed_enc.sv
module coef_fixed_enc #(
  parameter int unsigned MAG_W   = 63,
  parameter int unsigned FRAC_W  = 32,
  parameter int unsigned INT_W   = 3,
  parameter int unsigned FIELD_W = 12
) (
  input  logic [MAG_W-1:0]         mag_i,
  output logic [INT_W+FIELD_W-1:0] body_o
);
  localparam int unsigned LIM_W = FRAC_W + INT_W;
  localparam int unsigned CUT   = FRAC_W - FIELD_W;

  logic over;
  logic unused_lo;
  assign over      = |mag_i[MAG_W-1:LIM_W];
  assign body_o    = over ? '1 : mag_i[LIM_W-1:CUT];
  assign unused_lo = ^mag_i[CUT-1:0];
endmodule

// File: rtl/csc_coef_enc.sv
module csc_coef_enc
  import csc_coef_pkg::*;
#(
  parameter int unsigned IN_W = COEF_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            mode_i,
  input  logic [IN_W-1:0] coef_i,
  output logic            valid_o,
  output logic [15:0]     code_o
);
  localparam int unsigned MAG_W   = IN_W - 1;
  localparam int unsigned CODE_W  = 1 + EXP_W + FIELD_W;
  localparam int unsigned CLAMP_W = FRAC_W + N_RANGE - 4;
  localparam int unsigned IDX_W   = $clog2(N_RANGE);
  localparam int unsigned FIX_LIM = FRAC_W + EXP_W;

  logic               sign;
  logic [MAG_W-1:0]   mag;
  logic [CLAMP_W-1:0] mag_c;
  logic [IDX_W-1:0]   idx;
  logic [FIELD_W-1:0] field;
  logic [CODE_W-2:0]  fix_body;
  logic [CODE_W-2:0]  body;
  logic [CODE_W-1:0]  code_d;
  enc_mode_e          mode;

  assign sign = coef_i[IN_W-1];
  assign mag  = coef_i[MAG_W-1:0];
  assign mode = enc_mode_e'(mode_i);

  coef_range_sel #(
    .MAG_W(MAG_W), .FRAC_W(FRAC_W), .N_RANGE(N_RANGE),
    .CLAMP_W(CLAMP_W), .IDX_W(IDX_W)
  ) u_range (
    .mag_i(mag), .mag_o(mag_c), .idx_o(idx)
  );

  coef_mant_round #(
    .MAG_W(CLAMP_W), .FRAC_W(FRAC_W), .FIELD_W(FIELD_W),
    .RND_LSB(RND_LSB), .IDX_W(IDX_W)
  ) u_round (
    .mag_i(mag_c), .idx_i(idx), .field_o(field)
  );

  coef_fixed_enc #(
    .MAG_W(MAG_W), .FRAC_W(FRAC_W), .INT_W(EXP_W), .FIELD_W(FIELD_W)
  ) u_fixed (
    .mag_i(mag), .body_o(fix_body)
  );

  always_comb begin
    if (mode == ENC_FIXED) body = fix_body;
    else                   body = {range_code(idx), field};
    if (mag == '0) body = '0;  // zero always plain
    code_d = {sign, body};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= code_d;
    end
  end

  assert_sign_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> code_o[CODE_W-1] == $past(coef_i[IN_W-1]));

  assert_exp_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i) |=> (code_o[CODE_W-2 -: EXP_W] != 3'd4) &&
                             (code_o[CODE_W-2 -: EXP_W] != 3'd5));

  assert_mant_lsb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i) |=> code_o[RND_LSB-1:0] == '0);

  assert_fixed_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i && (|coef_i[MAG_W-1:FIX_LIM])) |=> code_o[CODE_W-2:0] == '1);

  assert_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && coef_i[MAG_W-1:0] == '0) |=> code_o[CODE_W-2:0] == '0);

  assert_valid_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(code_o));
endmodule

// File: tb/csc_coef_enc_bench.sv
`timescale 1ns/1ps
module csc_coef_enc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [63:0] coef_i = '0;
  logic        valid_o;
  logic [15:0] code_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csc_coef_enc u_csc_coef_enc (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .coef_i(coef_i), .valid_o(valid_o), .code_o(code_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        mode;
    logic [63:0] coef;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 1'b0, 64'h0000_0000_8000_0000, 16'h0800},  // R2 0.5
    '{8'd1, 1'b0, 64'h8000_0000_8000_0000, 16'h8800},  // R1 -0.5
    '{8'd2, 1'b0, 64'h0000_0001_0000_0000, 16'h7800},  // R2 1.0
    '{8'd2, 1'b0, 64'h0000_0000_4000_0000, 16'h1800},  // R2 0.25
    '{8'd2, 1'b0, 64'h0000_0000_2000_0000, 16'h2800},  // R2 0.125
    '{8'd2, 1'b0, 64'h0000_0002_0000_0000, 16'h6800},  // R2 2.0
    '{8'd3, 1'b0, 64'h0000_0000_1770_0000, 16'h3BB8},  // R3 code 3
    '{8'd3, 1'b0, 64'h0000_0000_2EE0_0000, 16'h2BB8},  // R3 code 2
    '{8'd3, 1'b0, 64'h0000_0000_1FFF_FFFF, 16'h3FF8},  // R3 saturate
    '{8'd3, 1'b0, 64'h0000_0000_FFFF_FFFF, 16'h0FF8},  // R3 saturate code 0
    '{8'd3, 1'b0, 64'h0000_0000_8050_0000, 16'h0808},  // R3 round up
    '{8'd3, 1'b0, 64'h0000_0000_8030_0000, 16'h0800},  // R3 round down
    '{8'd3, 1'b0, 64'h0000_0000_DB00_0000, 16'h0DB0},  // R3
    '{8'd4, 1'b0, 64'h0000_0064_0000_0000, 16'h6FF8},  // R4 100.0
    '{8'd4, 1'b0, 64'hC000_0000_0000_0000, 16'hEFF8},  // R4 bit 62, negative
    '{8'd4, 1'b0, 64'h0000_0004_0000_0000, 16'h6FF8},  // R4 exactly 4.0
    '{8'd2, 1'b0, 64'h0000_0003_8000_0000, 16'h6E00},  // R2 3.5
    '{8'd7, 1'b0, 64'h0000_0000_0000_0000, 16'h0000},  // R7 +0 float
    '{8'd7, 1'b0, 64'h8000_0000_0000_0000, 16'h8000},  // R7 -0 float
    '{8'd3, 1'b0, 64'h0000_0000_0000_0001, 16'h3000},  // R3 tiny nonzero
    '{8'd5, 1'b1, 64'h0000_0001_8000_0000, 16'h1800},  // R5 1.5
    '{8'd5, 1'b1, 64'h8000_0002_4000_0000, 16'hA400},  // R5 -2.25
    '{8'd5, 1'b1, 64'h0000_0005_000F_FFFF, 16'h5000},  // R5 truncation
    '{8'd6, 1'b1, 64'h0000_0009_0000_0000, 16'h7FFF},  // R6 9.0
    '{8'd6, 1'b1, 64'h0000_0008_0000_0000, 16'h7FFF},  // R6 exactly 8.0
    '{8'd5, 1'b1, 64'h0000_0007_FFFF_FFFF, 16'h7FFF},  // R5 below limit
    '{8'd7, 1'b1, 64'h8000_0000_0000_0000, 16'h8000},  // R7 -0 fixed
    '{8'd7, 1'b1, 64'h0000_0000_0000_0000, 16'h0000}   // R7 +0 fixed
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 code", code_o, 16'h0000);
    chk("R10 valid", {15'd0, valid_o}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      valid_i = 1'b1;
      mode_i  = VECS[i].mode;
      coef_i  = VECS[i].coef;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), code_o, VECS[i].exp);
      chk($sformatf("R8 valid vec%0d", i), {15'd0, valid_o}, 16'h0001);
    end

    // R9: idle input changes must not reach code_o
    valid_i = 1'b0;
    mode_i  = 1'b0;
    coef_i  = 64'h0000_0001_0000_0000;
    @(negedge clk);
    chk("R8 valid drop", {15'd0, valid_o}, 16'h0000);
    chk("R9 hold", code_o, 16'h0000);
    coef_i  = 64'h8000_0000_8000_0000;
    mode_i  = 1'b1;
    @(negedge clk);
    chk("R9 hold2", code_o, 16'h0000);

    // R8: single strobe, latency one cycle
    valid_i = 1'b1;
    mode_i  = 1'b0;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R8 strobe", code_o, 16'h8800);
    @(negedge clk);
    chk("R8 strobe end", {15'd0, valid_o}, 16'h0000);
    chk("R9 hold3", code_o, 16'h8800);

    // R10: reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R10 async code", code_o, 16'h0000);
    chk("R10 async valid", {15'd0, valid_o}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule